// File: doc/BRIEF.md
# Column-Based Pipelined Decimal Multiplier

This block multiplies two unsigned four-digit decimal numbers held in packed BCD and returns the full eight-digit BCD product. Every pair of operand digits is multiplied as a plain 4-bit by 4-bit binary product. These small binary products are gathered into columns that are two decimal digits wide, and each column is summed in binary. Only then is each column sum, a number below 1000 for the default size, turned into decimal.

Products whose digit weight falls on an even position form one set of columns. Products offset by one digit form a second set. After conversion, the low two digits of every column become two sum operands, one for each set. The upper digits become carry operands. With the default size the two carry sets never overlap, so they merge into one operand. Two levels of ripple decimal addition then finish the result.

The pipeline has four register stages: binary column sums, decimal column values, the first addition level, and the final product. A valid flag travels with the data. One operation may enter on every clock.

Top module: `bcdm_mul`

## Requirements
- R1: For operands whose digits are all 0 to 9, `product` equals the decimal product of `mcand` and `mplier`. In every BCD bus, digit d sits in bits [4d+3:4d], with digit 0 the least significant.
- R2: A result appears with `out_valid` high right after the fourth rising edge, counting the edge that samples `in_valid` high as the first. `out_valid` is low in every other cycle.
- R3: While `rst_n` is low, `out_valid` is 0 and `product` is all zeros. Operations still in flight when reset is asserted never appear.
- R4: In any cycle where `out_valid` is low, `product` keeps the value it had in the previous cycle.
- R5: A new operation is accepted on every clock. A burst of back-to-back inputs gives a burst of back-to-back results in the same order.
- R6: The largest operands, 9999 × 9999, give 99980001. No decimal adder produces a carry out of its most significant digit.
- R7: If either operand is zero, the product is 00000000.
- R8: Whenever `out_valid` is high, every digit of `product` is in the range 0 to 9.
- R9: Operand values presented while `in_valid` is low produce no result and do not change `product`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release it synchronously to `clk` |
| in_valid | input | 1 | Marks `mcand` and `mplier` as an operation to perform |
| mcand | input | 16 | Multiplicand, four BCD digits |
| mplier | input | 16 | Multiplier, four BCD digits |
| out_valid | output | 1 | Marks `product` as a new result |
| product | output | 32 | Product, eight BCD digits |

## Verification
The bench aims at the heaviest column loads. 9999 × 9999 fills every column to its maximum, so a column sum that is too narrow or a converter with a missing add-3 step would give wrong middle digits or an overflowing top digit. Zero operands and sparse patterns such as 9090 × 909 catch a product placed in the wrong column set or shifted by one digit, because the result would then show a stray power-of-ten error. Long back-to-back bursts, random idle gaps carrying garbage operands, and a reset asserted mid-flight expose a valid flag that slips out of step with its data, an output that changes without a result, or a pipeline that leaks stale work past reset.

// File: rtl/bcdm_pkg.sv
package bcdm_pkg;

  // bits needed to hold the binary sum of n digit products (each <= 81)
  function automatic int col_bits(input int n);
    return $clog2(81 * n + 1);
  endfunction

  // decimal digits needed to write the value v
  function automatic int dec_digits(input int v);
    int d;
    int r;
    d = 1;
    r = v;
    while (r > 9) begin
      r = r / 10;
      d = d + 1;
    end
    return d;
  endfunction

endpackage

// File: rtl/bcdm_digit_add.sv
// One-digit decimal adder: the low bit goes through a full adder, and the upper
// three bits are added with the decimal correction folded into the carry test.
module bcdm_digit_add (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output logic       cout
);
  logic       lo_s;
  logic       lo_c;
  logic [3:0] hi_sum;
  logic [3:0] hi_tot;
  logic [2:0] hi_dig;

  assign {lo_c, lo_s} = {1'b0, a[0]} + {1'b0, b[0]} + {1'b0, cin};
  assign hi_sum       = {1'b0, a[3:1]} + {1'b0, b[3:1]};
  assign hi_tot       = hi_sum + {3'b000, lo_c};
  // hi_tot counts pairs: five pairs make one decimal ten
  assign cout         = (hi_tot >= 4'd5);
  assign hi_dig       = cout ? 3'(hi_tot - 4'd5) : hi_tot[2:0];
  assign sum          = {hi_dig, lo_s};

  // R1: the split adder must match integer addition on valid digits
  always_comb begin
    if (!$isunknown({a, b, cin}) && (a <= 4'd9) && (b <= 4'd9)) begin
      a_r1_digit_sum: assert ((int'(cout) * 10 + int'(sum)) == (int'(a) + int'(b) + int'(cin)));
      a_r8_digit_range: assert (sum <= 4'd9);
    end
  end
endmodule

// File: rtl/bcdm_ripple_add.sv
// Multi-digit decimal ripple adder built from split-carry digit adders.
module bcdm_ripple_add #(
  parameter int ND = 8
) (
  input  logic [4*ND-1:0] a,
  input  logic [4*ND-1:0] b,
  input  logic            cin,
  output logic [4*ND-1:0] sum,
  output logic            cout
);
  logic [ND:0] carry;

  assign carry[0] = cin;

  for (genvar d = 0; d < ND; d++) begin : g_dig
    bcdm_digit_add u_dig (
      .a    (a[4*d +: 4]),
      .b    (b[4*d +: 4]),
      .cin  (carry[d]),
      .sum  (sum[4*d +: 4]),
      .cout (carry[d+1])
    );
  end

  assign cout = carry[ND];
endmodule

// File: rtl/bcdm_bin2bcd.sv
// Shift-and-add-3 conversion of one column's binary sum to decimal digits.
module bcdm_bin2bcd #(
  parameter int IW = 9,
  parameter int OD = 3
) (
  input  logic [IW-1:0]   bin,
  output logic [4*OD-1:0] bcd
);
  logic [4*OD-1:0] acc;

  always_comb begin
    acc = '0;
    for (int b = IW - 1; b >= 0; b--) begin
      for (int d = 0; d < OD; d++) begin
        if (acc[4*d +: 4] >= 4'd5) begin
          acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
        end
      end
      acc = {acc[4*OD-2:0], bin[b]};
    end
  end

  assign bcd = acc;

  // R1: the decimal value of the digits equals the binary input
  always_comb begin
    automatic int val = 0;
    automatic int wt  = 1;
    for (int d = 0; d < OD; d++) begin
      val = val + int'(bcd[4*d +: 4]) * wt;
      wt  = wt * 10;
    end
    if (!$isunknown(bin)) begin
      a_r1_conv_value: assert (val == int'(bin));
    end
  end
endmodule

// File: rtl/bcdm_mul.sv
// Four-stage decimal multiplier with binary column reduction.
module bcdm_mul #(
  parameter int N_DIG = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [4*N_DIG-1:0]   mcand,
  input  logic [4*N_DIG-1:0]   mplier,
  output logic                 out_valid,
  output logic [8*N_DIG-1:0]   product
);
  localparam int PD  = 2 * N_DIG;                        // product digits
  localparam int PW  = 4 * PD;                           // product bits
  localparam int NCA = N_DIG;                            // even-weight columns
  localparam int NCB = N_DIG - 1;                        // odd-weight columns
  localparam int CW  = bcdm_pkg::col_bits(N_DIG);        // column sum bits
  localparam int CD  = bcdm_pkg::dec_digits(81 * N_DIG); // column decimal digits

  // ---------------- stage 1: digit products and binary column sums
  logic [N_DIG-1:0][N_DIG-1:0][7:0] dprod;
  logic [NCA-1:0][CW-1:0] colA_n, colA_q;
  logic [NCB-1:0][CW-1:0] colB_n, colB_q;
  logic v1_q;

  for (genvar i = 0; i < N_DIG; i++) begin : g_row
    for (genvar j = 0; j < N_DIG; j++) begin : g_col
      assign dprod[i][j] = {4'd0, mcand[4*i +: 4]} * {4'd0, mplier[4*j +: 4]};
    end
  end

  always_comb begin
    colA_n = '0;
    colB_n = '0;
    for (int i = 0; i < N_DIG; i++) begin
      for (int j = 0; j < N_DIG; j++) begin
        if (((i + j) % 2) == 0) begin
          colA_n[(i + j) / 2] = colA_n[(i + j) / 2] + CW'(dprod[i][j]);
        end else begin
          colB_n[(i + j) / 2] = colB_n[(i + j) / 2] + CW'(dprod[i][j]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      colA_q <= '0;
      colB_q <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        colA_q <= colA_n;
        colB_q <= colB_n;
      end
    end
  end

  // ---------------- stage 2: per-column binary to decimal
  logic [NCA-1:0][4*CD-1:0] decA_n, decA_q;
  logic [NCB-1:0][4*CD-1:0] decB_n, decB_q;
  logic v2_q;

  for (genvar k = 0; k < NCA; k++) begin : g_convA
    bcdm_bin2bcd #(.IW(CW), .OD(CD)) u_conv (
      .bin (colA_q[k]),
      .bcd (decA_n[k])
    );
  end

  for (genvar k = 0; k < NCB; k++) begin : g_convB
    bcdm_bin2bcd #(.IW(CW), .OD(CD)) u_conv (
      .bin (colB_q[k]),
      .bcd (decB_n[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q   <= 1'b0;
      decA_q <= '0;
      decB_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        decA_q <= decA_n;
        decB_q <= decB_n;
      end
    end
  end

  // ---------------- stage 3: align operands, first decimal addition level
  logic [PD-1:0][3:0] sumA, sumB, carA, carB;
  logic [PW-1:0] l1s_n, l1c_n, l1s_q, l1c_q;
  logic cout_s, cout_c;
  logic v3_q;

  always_comb begin
    sumA = '0;
    sumB = '0;
    carA = '0;
    carB = '0;
    for (int k = 0; k < NCA; k++) begin
      sumA[2*k]     = decA_q[k][3:0];
      sumA[2*k + 1] = decA_q[k][7:4];
      for (int c = 2; c < CD; c++) begin
        if ((2*k + c) < PD) begin
          carA[2*k + c] = decA_q[k][4*c +: 4];
        end
      end
    end
    for (int k = 0; k < NCB; k++) begin
      sumB[2*k + 1] = decB_q[k][3:0];
      sumB[2*k + 2] = decB_q[k][7:4];
      for (int c = 2; c < CD; c++) begin
        if ((2*k + 1 + c) < PD) begin
          carB[2*k + 1 + c] = decB_q[k][4*c +: 4];
        end
      end
    end
  end

  bcdm_ripple_add #(.ND(PD)) u_add_sum (
    .a    (sumA),
    .b    (sumB),
    .cin  (1'b0),
    .sum  (l1s_n),
    .cout (cout_s)
  );

  if (CD == 3) begin : g_car_merge
    // single carry digit per column: the two sets interleave without overlap
    assign l1c_n  = carA | carB;
    assign cout_c = 1'b0;
  end else begin : g_car_add
    bcdm_ripple_add #(.ND(PD)) u_add_car (
      .a    (carA),
      .b    (carB),
      .cin  (1'b0),
      .sum  (l1c_n),
      .cout (cout_c)
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v3_q  <= 1'b0;
      l1s_q <= '0;
      l1c_q <= '0;
    end else begin
      v3_q <= v2_q;
      if (v2_q) begin
        l1s_q <= l1s_n;
        l1c_q <= l1c_n;
      end
    end
  end

  // ---------------- stage 4: second decimal addition level
  logic [PW-1:0] fin_n;
  logic cout_f;
  logic v4_q;
  logic [PW-1:0] prod_q;

  bcdm_ripple_add #(.ND(PD)) u_add_fin (
    .a    (l1s_q),
    .b    (l1c_q),
    .cin  (1'b0),
    .sum  (fin_n),
    .cout (cout_f)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v4_q   <= 1'b0;
      prod_q <= '0;
    end else begin
      v4_q <= v3_q;
      if (v3_q) begin
        prod_q <= fin_n;
      end
    end
  end

  assign out_valid = v4_q;
  assign product   = prod_q;

  // ---------------- assertions
  function automatic logic all_bcd(input logic [PW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < PD; d++) begin
      if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r6_no_overflow_l1: assert property (@(posedge clk) disable iff (!rst_n)
    v2_q |-> (!cout_s && !cout_c));

  a_r6_no_overflow_fin: assert property (@(posedge clk) disable iff (!rst_n)
    v3_q |-> !cout_f);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(product));

  a_r8_digits_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> all_bcd(product));
endmodule

// File: tb/bcdm_mul_tb.sv
`timescale 1ns/1ps
module bcdm_mul_tb;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [15:0]   mcand = '0;
  logic [15:0]   mplier = '0;
  logic          out_valid;
  logic [31:0]   product;

  bcdm_mul #(.N_DIG(ND)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mcand     (mcand),
    .mplier    (mplier),
    .out_valid (out_valid),
    .product   (product)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_run = 0;
  int    n_fail = 0;
  logic [31:0] last_prod = '0;
  int    q_due[$];
  int    q_exp[$];
  string q_tag[$];

  function automatic logic [31:0] to_bcd(input int v, input int nd);
    logic [31:0] r;
    int x;
    r = '0;
    x = v;
    for (int d = 0; d < nd; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic sample();
    bit ev;
    bit dig_ok;
    ev = (q_due.size() > 0) && (q_due[0] == cyc);
    chk(out_valid == ev, "R2", "out_valid", out_valid, ev);
    if (ev) begin
      if (out_valid) begin
        chk(product == to_bcd(q_exp[0], 8), q_tag[0], "product", product, to_bcd(q_exp[0], 8));
        dig_ok = 1'b1;
        for (int d = 0; d < 8; d++) if (product[4*d +: 4] > 4'd9) dig_ok = 1'b0;
        chk(dig_ok, "R8", "digit range", product, to_bcd(q_exp[0], 8));
        last_prod = product;
      end
      void'(q_due.pop_front());
      void'(q_exp.pop_front());
      void'(q_tag.pop_front());
    end else begin
      // R4 / R9: no result this cycle, so the output must hold
      chk(product == last_prod, "R4", "hold", product, last_prod);
    end
  endtask

  task automatic step(input bit v, input int a, input int b, input string tag);
    @(negedge clk);
    sample();
    in_valid = v;
    mcand    = to_bcd(a, 4);
    mplier   = to_bcd(b, 4);
    if (v) begin
      q_due.push_back(cyc + 4);
      q_exp.push_back(a * b);
      q_tag.push_back(tag);
    end
  endtask

  task automatic op(input int a, input int b, input string tag);
    step(1'b1, a, b, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      // R9: garbage operands with in_valid low
      step(1'b0, $urandom_range(0, 9999), $urandom_range(0, 9999), "R9");
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R3: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R3", "out_valid in reset", out_valid, 0);
    chk(product == '0, "R3", "product in reset", product, 0);
    rst_n = 1'b1;
    last_prod = '0;
    idle(3);

    // corners
    op(9999, 9999, "R6");
    op(0, 1234, "R7");
    op(5678, 0, "R7");
    op(0, 0, "R7");
    op(1, 1, "R1");
    op(9, 9, "R1");
    op(9090, 909, "R1");
    op(1000, 1000, "R1");
    op(5555, 5555, "R1");
    op(1111, 9999, "R1");
    idle(6);

    // R5: back-to-back burst
    for (int i = 0; i < 200; i++) op($urandom_range(0, 9999), $urandom_range(0, 9999), "R5");
    idle(6);

    // random with idle gaps
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 1) == 1) op($urandom_range(0, 9999), $urandom_range(0, 9999), "R1");
      else idle(1);
    end
    idle(6);

    // R3: reset with work in flight
    op(4321, 8765, "R3");
    op(9999, 9999, "R3");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R3", "out_valid after mid reset", out_valid, 0);
    chk(product == '0, "R3", "product after mid reset", product, 0);
    q_due.delete();
    q_exp.delete();
    q_tag.delete();
    last_prod = '0;
    rst_n = 1'b1;
    idle(8);

    op(9999, 9999, "R6");
    op(7, 3, "R1");
    idle(8);
    chk(q_due.size() == 0, "R2", "results outstanding", q_due.size(), 0);

    summary();
    $finish;
  end
endmodule